// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit binary timer channel. A count value and a 3-bit mode are captured together on a load strobe. The channel then advances once per count-enable tick and shapes an output waveform that depends on the mode. There are six behaviours: a terminal-count flag, a retriggerable one-shot, a periodic single-tick pulse, a square wave, and two one-tick strobes (one started by software, one started by hardware). A gate input either suspends counting or restarts the sequence, depending on the mode.

The live count is always visible on a readback port, so a host wrapper can sample it at any time. A loaded value of zero means a full 65536-tick count. The host bus, control-word decoding, byte sequencing and interrupt routing all belong to the surrounding logic.

In the requirements, "elapsed ticks" (written E) is the number of qualifying ticks since the last load or gate retrigger. N is the effective count.

Top module: `ict_channel`

## Requirements
- R1: A loaded value of 0 is treated as N = 65536. Any other value v gives N = v.
- R2: A load strobe captures `load_cnt_i` and `mode_sel_i` and sets E to 0. In the next cycle, `count_o` equals the loaded value. Load takes priority over a gate retrigger and over a tick in the same cycle.
- R3: Mode 0 (terminal flag): `wave_o` is 0 while E < N and 1 once E >= N, until the next load. `count_o` = (N − E) mod 65536.
- R4: Mode 1 (one-shot): `wave_o` is 1 while E < N and 0 afterwards. `count_o` = (N − E) mod 65536. A tick counts even when the gate is low.
- R5: Mode 2 (rate): `wave_o` is 1 exactly when E mod N = 0 and E ≠ 0, so the pulse lasts one tick and repeats every N ticks. `count_o` = (N − (E mod N)) mod 65536.
- R6: Mode 3 (square): with P = E mod N and H = (N+1)/2 rounded down, `wave_o` = 1 when P < H and 0 otherwise. The pattern repeats every N ticks.
- R7: Mode 3 readback: `count_o` = (N − 2Q) mod 65536. Q = P in the high half and Q = P − H in the low half, so the count drops by two per tick and reloads at each half boundary.
- R8: Modes 4 and 5 (strobes): `wave_o` is 1 only while E = N, which gives a single one-tick strobe with no repeat. `count_o` = (N − E) mod 65536.
- R9: In modes 1, 2, 3 and 5, a gate that is 1 in a cycle after being 0 in the previous cycle sets E to 0 at that clock edge. Any tick in that cycle is then ignored.
- R10: In modes 0, 2, 3 and 4, a tick while the gate is low is ignored, so `count_o` and `wave_o` hold. Modes 1 and 5 count ticks whatever the gate level.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: While reset is asserted, the channel holds mode 0 with a loaded value of 0 and E = 0, so `count_o` = 0 and `wave_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count-enable tick, one clock wide per count step |
| gate_i | input | 1 | Gate level (suspend or retrigger, depending on mode) |
| load_i | input | 1 | Load strobe for count and mode |
| load_cnt_i | input | CNT_W | Initial count (0 means 2^CNT_W) |
| mode_sel_i | input | 3 | Counting mode code |
| count_o | output | CNT_W | Live count readback |
| wave_o | output | 1 | Mode-dependent output waveform |

## Verification
Every effect lands at the first clock edge after the stimulus. A load, a gate retrigger or a qualifying tick seen at edge k changes the internal registers at edge k. `count_o` and `wave_o` are combinational from those registers, so they show the new value for the whole cycle after edge k, with no further delay. The bench drives inputs and samples outputs on the falling edge. It keeps a reference of E, N and the mode, updated with the same priority (load, then retrigger, then tick). Before each rising edge it compares both outputs against values computed from that reference. The long zero-count strobe run confirms the 65536-tick case at the exact edge.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } ict_mode_e;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_HIT  = 2'd1,
    PH_DONE = 2'd2
  } ict_phase_e;

  // Codes 6 and 7 alias the periodic modes.
  function automatic ict_mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd6:    fold_mode = MODE_RATE;
      3'd7:    fold_mode = MODE_SQUARE;
      default: fold_mode = ict_mode_e'(code);
    endcase
  endfunction

  // Modes in which a low gate freezes counting.
  function automatic logic gate_suspends(input ict_mode_e m);
    gate_suspends = (m == MODE_TERM) || (m == MODE_RATE) ||
                    (m == MODE_SQUARE) || (m == MODE_SWSTROBE);
  endfunction

  // Modes in which a gate rising edge restarts the sequence.
  function automatic logic gate_retriggers(input ict_mode_e m);
    gate_retriggers = (m == MODE_ONESHOT) || (m == MODE_RATE) ||
                      (m == MODE_SQUARE) || (m == MODE_HWSTROBE);
  endfunction

endpackage

// File: rtl/ict_gate_ctl.sv
module ict_gate_ctl
  import ict_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gate_i,
  input  logic      tick_i,
  input  logic      load_i,
  input  ict_mode_e mode_i,
  output logic      restart_o,
  output logic      advance_o
);

  logic gate_q;
  logic gate_d;
  logic rise_w;

  always_comb begin
    gate_d    = gate_i;
    rise_w    = gate_i & ~gate_q;
    restart_o = load_i | (rise_w & gate_retriggers(mode_i));
    advance_o = tick_i & (gate_i | ~gate_suspends(mode_i)) & ~restart_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

endmodule

// File: rtl/ict_oneshot.sv
module ict_oneshot
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             advance_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output ict_phase_e       phase_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ict_phase_e       ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (restart_i) begin
      cnt_d = init_i;
      ph_d  = PH_RUN;
    end else if (advance_i) begin
      cnt_d = cnt_q - ONE;
      case (ph_q)
        PH_RUN:  if (cnt_q == ONE) ph_d = PH_HIT;
        PH_HIT:  ph_d = PH_DONE;
        default: ph_d = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_RUN;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = ph_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DONE && !restart_i) |=> (ph_q == PH_DONE)); // R3
  AST_HIT_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HIT && advance_i && !restart_i) |=> (ph_q == PH_DONE)); // R8

endmodule

// File: rtl/ict_periodic.sv
module ict_periodic #(
  parameter int CNT_W = 16,
  localparam int PW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          advance_i,
  input  logic [PW-1:0] nfull_i,
  output logic [PW-1:0] pos_o,
  output logic          pulse_o
);

  logic [PW-1:0] pos_q, pos_d;
  logic          pulse_q, pulse_d;
  logic          last_w;

  always_comb begin
    last_w  = (pos_q == nfull_i - PW'(1));
    pos_d   = pos_q;
    pulse_d = pulse_q;
    if (restart_i) begin
      pos_d   = '0;
      pulse_d = 1'b0;
    end else if (advance_i) begin
      pos_d   = last_w ? '0 : pos_q + PW'(1);
      pulse_d = last_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      pulse_q <= pulse_d;
    end
  end

  assign pos_o   = pos_q;
  assign pulse_o = pulse_q;

  AST_POS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < nfull_i); // R5
  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !restart_i && last_w) |=> (pulse_q && pos_q == '0)); // R5

endmodule

// File: rtl/ict_channel.sv
module ict_channel
  import ict_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [2:0]       mode_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wave_o
);

  localparam int PW = CNT_W + 1;

  ict_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] init_q, init_d;
  logic [PW-1:0]    nfull_w, half_w, sq_off_w, pos_w;
  logic [CNT_W-1:0] os_cnt_w;
  ict_phase_e       os_ph_w;
  logic             pulse_w, restart_w, advance_w, high_w;

  always_comb begin
    mode_d = mode_q;
    init_d = init_q;
    if (load_i) begin
      mode_d = fold_mode(mode_sel_i);
      init_d = load_cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TERM;
      init_q <= '0;
    end else begin
      mode_q <= mode_d;
      init_q <= init_d;
    end
  end

  // Zero means a full 2^CNT_W count.
  assign nfull_w = (init_q == '0) ? (PW'(1) << CNT_W) : {1'b0, init_q};

  ict_gate_ctl u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_i    (gate_i),
    .tick_i    (tick_en_i),
    .load_i    (load_i),
    .mode_i    (mode_q),
    .restart_o (restart_w),
    .advance_o (advance_w)
  );

  ict_oneshot #(.CNT_W(CNT_W)) u_oneshot (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_w),
    .advance_i (advance_w),
    .init_i    (init_d),
    .cnt_o     (os_cnt_w),
    .phase_o   (os_ph_w)
  );

  ict_periodic #(.CNT_W(CNT_W)) u_periodic (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_w),
    .advance_i (advance_w),
    .nfull_i   (nfull_w),
    .pos_o     (pos_w),
    .pulse_o   (pulse_w)
  );

  always_comb begin
    half_w   = (nfull_w >> 1) + PW'(nfull_w[0]);
    high_w   = (pos_w < half_w);
    sq_off_w = high_w ? pos_w : (pos_w - half_w);
    count_o  = os_cnt_w;
    wave_o   = 1'b0;
    case (mode_q)
      MODE_TERM:    wave_o = (os_ph_w != PH_RUN);
      MODE_ONESHOT: wave_o = (os_ph_w == PH_RUN);
      MODE_RATE: begin
        wave_o  = pulse_w;
        count_o = init_q - pos_w[CNT_W-1:0];
      end
      MODE_SQUARE: begin
        wave_o  = high_w;
        count_o = init_q - {sq_off_w[CNT_W-2:0], 1'b0};
      end
      default:      wave_o = (os_ph_w == PH_HIT);
    endcase
  end

  AST_LOAD_SHOWS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_cnt_i))); // R2
  AST_RETRIG_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_w && !load_i) |=> (count_o == $past(init_q))); // R9
  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !gate_i && gate_suspends(mode_q)) |=> ($stable(count_o) && $stable(wave_o))); // R10
  AST_TERM_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TERM && wave_o && !load_i) |=> wave_o); // R3

endmodule

// File: tb/tb_ict_channel.sv
module tb_ict_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en_i, gate_i, load_i;
  logic [15:0] load_cnt_i;
  logic [2:0]  mode_sel_i;
  logic [15:0] count_o;
  logic        wave_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  int    m_mode, m_n, d;
  logic  g_prev;
  string dir_tag = "";

  always #4 clk = ~clk;

  ict_channel #(.CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .gate_i(gate_i),
    .load_i(load_i), .load_cnt_i(load_cnt_i), .mode_sel_i(mode_sel_i),
    .count_o(count_o), .wave_o(wave_o)
  );

  function automatic int fold(input int code);
    return (code == 6) ? 2 : (code == 7) ? 3 : code;
  endfunction

  function automatic logic exp_wave(input int md, input int n, input int e);
    int p, h;
    p = e % n; h = (n + 1) / 2;
    case (md)
      0: return e >= n;
      1: return e < n;
      2: return (p == 0) && (e != 0);
      3: return p < h;
      default: return e == n;
    endcase
  endfunction

  function automatic logic [15:0] exp_count(input int md, input int n, input int e);
    int p, h, q;
    p = e % n; h = (n + 1) / 2;
    case (md)
      2: return 16'((n - p) & 32'hFFFF);
      3: begin
        q = (p < h) ? p : p - h;
        return 16'((n - 2 * q) & 32'hFFFF);
      end
      default: return 16'((n - e) & 32'hFFFF);
    endcase
  endfunction

  function automatic string wave_tag(input int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    string tw, tc;
    tw = (dir_tag != "") ? dir_tag : wave_tag(m_mode);
    tc = (dir_tag != "") ? dir_tag : ((m_mode == 3) ? "R7" : "R2");
    chk(tw, "wave", {15'd0, wave_o}, {15'd0, exp_wave(m_mode, m_n, d)});
    chk(tc, "count", count_o, exp_count(m_mode, m_n, d));
  endtask

  // Called just after a falling edge: check, drive, advance reference, wait one cycle.
  task automatic step(input logic ld, input logic [15:0] val, input logic [2:0] ms,
                      input logic g, input logic tk);
    bit retrig, susp;
    compare_now();
    load_i = ld; load_cnt_i = val; mode_sel_i = ms; gate_i = g; tick_en_i = tk;
    retrig = g && !g_prev && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
    susp   = (m_mode == 0 || m_mode == 2 || m_mode == 3 || m_mode == 4);
    if (ld) begin
      m_mode = fold(int'(ms)); m_n = (val == 0) ? 65536 : int'(val); d = 0;
    end else if (retrig) begin
      d = 0;
    end else if (tk && (g || !susp)) begin
      d++;
    end
    g_prev = g;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] ms, input logic [15:0] val, input int cycles);
    step(1'b1, val, ms, 1'b1, 1'b0);
    for (int i = 0; i < cycles; i++) step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; tick_en_i = 1'b0; gate_i = 1'b0; load_i = 1'b0;
    load_cnt_i = 16'd0; mode_sel_i = 3'd0;
    m_mode = 0; m_n = 65536; d = 0; g_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "count in reset", count_o, 16'd0);
    chk("R12", "wave in reset", {15'd0, wave_o}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero count in mode 0 wraps readback, in mode 4 strobes at 65536
    dir_tag = "R1";
    run(3'd0, 16'd0, 5);
    run(3'd4, 16'd0, 65538);
    dir_tag = "";

    // R9: retrigger in one-shot and square modes
    dir_tag = "R9";
    run(3'd1, 16'd5, 3);
    step(1'b0, 16'd0, 3'd0, 1'b0, 1'b1);
    step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
    run(3'd3, 16'd6, 4);
    step(1'b0, 16'd0, 3'd0, 1'b0, 1'b0);
    step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
    dir_tag = "";

    // R10: low gate freezes mode 2 and mode 0, not mode 5
    dir_tag = "R10";
    run(3'd2, 16'd4, 2);
    for (int i = 0; i < 5; i++) step(1'b0, 16'd0, 3'd0, 1'b0, 1'b1);
    run(3'd0, 16'd3, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 16'd0, 3'd0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 16'd0, 3'd0, 1'b1, 1'b1);
    run(3'd5, 16'd3, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 16'd0, 3'd0, 1'b0, 1'b1);
    dir_tag = "";

    // R11: alias codes
    dir_tag = "R11";
    run(3'd6, 16'd3, 8);
    run(3'd7, 16'd5, 12);
    dir_tag = "";

    // Odd square wave and count of one
    run(3'd3, 16'd7, 16);
    run(3'd2, 16'd1, 4);
    run(3'd3, 16'd1, 4);

    // Constrained random mix, all modes
    for (int i = 0; i < 6000; i++) begin
      logic        ld, g, tk;
      logic [15:0] v;
      ld = ($urandom_range(0, 99) < 5);
      g  = ($urandom_range(0, 99) < 85);
      tk = ($urandom_range(0, 99) < 75);
      v  = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(0, 65535))
                                        : 16'($urandom_range(1, 12));
      step(ld, v, 3'($urandom_range(0, 7)), g, tk);
    end
    compare_now();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule